// File: doc/BRIEF.md
# Receive Descriptor Write-Back Engine

This block sits behind an Ethernet MAC receiver and moves each incoming frame into host memory. Host memory holds a circular ring of fixed-size receive descriptors. Each descriptor carries an ownership flag, a length field and a pointer to a data buffer. While no frame is in flight, the engine reads the current descriptor ahead of time. If the descriptor belongs to the MAC, the engine caches its buffer pointer and waits for a frame.

The frame arrives as a byte stream. The final byte carries the receiver's error flags and the address-match classification. The engine stores the bytes in the buffer and counts them, clipping at the programmed buffer size. It then writes the length field, and after that the status word, which also returns the descriptor to the host. Finally it moves to the next slot of the ring.

A frame that starts while no MAC-owned descriptor is ready is thrown away and flagged. The engine also keeps two sticky interrupt flags and a counter of good frames. Software configures the block through a small write port: the buffer size and the two halves of the ring base address.

Top module: `rxwb_engine`

## Requirements
- R1: A frame is stored only when the current descriptor's status halfword (descriptor offset 0) has bit 15 set. A frame that starts while no such descriptor is ready leaves the ring memory unchanged, does not advance the ring and sets interrupt flag bit 1 (no descriptor).
- R2: Frame byte k is written to address P+k, where P is the buffer pointer held at descriptor offsets 4 (low half) and 6 (high half). Memory is little-endian: an even address uses lane 0 and an odd address uses lane 1.
- R3: The length halfword at descriptor offset 2 receives the frame's byte count, CRC bytes included, in bits 11:0, with bits 15:12 zero.
- R4: The status halfword is written after the length halfword. It has bit 15 clear. Bit 14 marks a good frame, which is one with none of bits 11..6 set. The flags sampled with the last byte go to bit 11 (PHY error), bit 10 (dribble) and bit 6 (CRC error).
- R5: Length checks: bit 9 is set when the count exceeds the buffer size, and bytes past the buffer size are not written. Bit 8 is set when the count exceeds 1518. Bit 7 is set when the count is below 64.
- R6: On a good frame, status bits 5..0 carry the classification {broadcast, multicast, hash hit, exact-table hit, table index[1:0]}. On a bad frame they are zero.
- R7: Descriptor i sits at base + 32*i. After slot RING-1 the engine returns to slot 0.
- R8: Configuration writes: offset 0x18 sets the buffer size (1536 after reset). Offsets 0x34 and 0x38 set the low and high halves of the ring base, and either write restarts the ring at slot 0.
- R9: Interrupt flag bit 0 (frame done) is set at every write-back. Both flags are sticky and clear only through a 1 on the matching irq_clear bit. Both are 0 after reset.
- R10: rx_good_count is 0 after reset and increments once per frame whose status has bit 14 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register offset |
| cfg_wdata | input | 16 | Configuration write data |
| rx_valid | input | 1 | Frame byte valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Last byte of frame (CRC included) |
| rx_phy_err | input | 1 | PHY error flag, valid with rx_last |
| rx_dribble | input | 1 | Dribble flag, valid with rx_last |
| rx_crc_err | input | 1 | CRC error flag, valid with rx_last |
| rx_bcast | input | 1 | Broadcast destination, valid with rx_last |
| rx_mcast | input | 1 | Multicast destination, valid with rx_last |
| rx_hash_hit | input | 1 | Multicast hash hit, valid with rx_last |
| rx_mid_hit | input | 1 | Exact address table hit, valid with rx_last |
| rx_mid_idx | input | 2 | Index of matched table entry |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_wdata | output | 16 | Memory write data |
| mem_wbe | output | 2 | Memory write byte lanes |
| mem_re | output | 1 | Memory read strobe |
| mem_raddr | output | 32 | Memory read byte address (even) |
| mem_rdata | input | 16 | Read data, one cycle after mem_re |
| irq_status | output | 2 | Sticky flags: bit 0 frame done, bit 1 no descriptor |
| irq_clear | input | 2 | Write-1-to-clear for irq_status |
| rx_good_count | output | 16 | Good-frame counter |

## Verification
The assertions assume that memory answers a read in the cycle after mem_re. They also assume that the buffer size stays fixed while a frame is being stored and that the ring base is not rewritten during a frame or a write-back. The bench keeps to this by programming configuration only between frames. It also holds a gap of several dozen cycles after each frame so that the next descriptor fetch finishes. The one exception is the no-descriptor case, where a frame is sent on purpose while the engine is still polling a host-owned slot.

// File: rtl/rxwb_pkg.sv
package rxwb_pkg;

  typedef enum logic [3:0] {
    S_RD_ST,   // issue read of status halfword
    S_RD_PL,   // issue read of pointer low half
    S_CHK,     // status arrives: test ownership
    S_GET_PL,  // pointer low arrives
    S_GET_PH,  // pointer high arrives
    S_READY,   // descriptor cached, waiting for a frame
    S_RECV,    // storing frame bytes
    S_WB_LEN,  // write length halfword
    S_WB_ST    // write status halfword, release descriptor
  } rx_state_e;

  localparam int ST_OWN  = 15;
  localparam int ST_OK   = 14;
  localparam int ST_PHY  = 11;
  localparam int ST_DRIB = 10;
  localparam int ST_OVF  = 9;
  localparam int ST_LONG = 8;
  localparam int ST_RUNT = 7;
  localparam int ST_CRC  = 6;

  typedef struct packed {
    logic bcast;
    logic mcast;
    logic hash_hit;
    logic mid_hit;
    logic [1:0] mid_idx;
  } rx_class_t;

  typedef struct packed {
    logic phy_err;
    logic dribble;
    logic crc_err;
  } rx_err_t;

endpackage

// File: rtl/rxwb_cfg.sv
module rxwb_cfg #(
  parameter int AW        = 32,
  parameter int BSZ_W     = 16,
  parameter int BUF_RESET = 1536,
  parameter logic [7:0] OFS_BUFSZ   = 8'h18,
  parameter logic [7:0] OFS_BASE_LO = 8'h34,
  parameter logic [7:0] OFS_BASE_HI = 8'h38
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [AW-1:0]    ring_base,
  output logic [BSZ_W-1:0] buf_size,
  output logic             rebase
);
  logic [31:0] base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      buf_size <= BSZ_W'(BUF_RESET);
      rebase   <= 1'b0;
    end else begin
      rebase <= 1'b0;
      if (cfg_we) begin
        if (cfg_addr == OFS_BUFSZ)   buf_size <= BSZ_W'(cfg_wdata);
        if (cfg_addr == OFS_BASE_LO) begin base_q[15:0]  <= cfg_wdata; rebase <= 1'b1; end
        if (cfg_addr == OFS_BASE_HI) begin base_q[31:16] <= cfg_wdata; rebase <= 1'b1; end
      end
    end
  end

  assign ring_base = base_q[AW-1:0];
endmodule

// File: rtl/rxwb_status.sv
module rxwb_status
  import rxwb_pkg::*;
#(
  parameter int LEN_W     = 12,
  parameter int BSZ_W     = 16,
  parameter int MAX_FRAME = 1518,
  parameter int MIN_FRAME = 64
) (
  input  logic [LEN_W-1:0] len,
  input  logic [BSZ_W-1:0] buf_size,
  input  rx_err_t          err,
  input  rx_class_t        cls,
  output logic [15:0]      status_word,
  output logic             frame_ok
);
  logic ovf, too_long, runt;

  always_comb begin
    ovf      = BSZ_W'(len) > buf_size;
    too_long = int'(len) > MAX_FRAME;
    runt     = int'(len) < MIN_FRAME;
    frame_ok = !(err.phy_err || err.dribble || err.crc_err || ovf || too_long || runt);
    status_word          = '0;
    status_word[ST_OK]   = frame_ok;
    status_word[ST_PHY]  = err.phy_err;
    status_word[ST_DRIB] = err.dribble;
    status_word[ST_OVF]  = ovf;
    status_word[ST_LONG] = too_long;
    status_word[ST_RUNT] = runt;
    status_word[ST_CRC]  = err.crc_err;
    if (frame_ok) status_word[5:0] = cls;
  end
endmodule

// File: rtl/rxwb_events.sv
module rxwb_events #(
  parameter int CNT_W = 16,
  parameter int IRQ_N = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IRQ_N-1:0] irq_set,
  input  logic [IRQ_N-1:0] irq_clear,
  input  logic             good_pulse,
  output logic [IRQ_N-1:0] irq_status,
  output logic [CNT_W-1:0] good_count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_status <= '0;
      good_count <= '0;
    end else begin
      irq_status <= (irq_status & ~irq_clear) | irq_set;
      if (good_pulse) good_count <= good_count + 1'b1;
    end
  end

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq_status[0] && !irq_clear[0]) |=> irq_status[0]);

  a_r10_count_step: assert property (@(posedge clk) disable iff (rst)
    (good_count != $past(good_count)) |-> (good_count == $past(good_count) + CNT_W'(1)));
endmodule

// File: rtl/rxwb_engine.sv
module rxwb_engine
  import rxwb_pkg::*;
#(
  parameter int AW         = 32,
  parameter int RING       = 4,
  parameter int DESC_BYTES = 32,
  parameter int LEN_W      = 12,
  parameter int BSZ_W      = 16,
  parameter int CNT_W      = 16,
  parameter int BUF_RESET  = 1536,
  parameter int MAX_FRAME  = 1518,
  parameter int MIN_FRAME  = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [7:0]       cfg_addr,
  input  logic [15:0]      cfg_wdata,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  input  logic             rx_phy_err,
  input  logic             rx_dribble,
  input  logic             rx_crc_err,
  input  logic             rx_bcast,
  input  logic             rx_mcast,
  input  logic             rx_hash_hit,
  input  logic             rx_mid_hit,
  input  logic [1:0]       rx_mid_idx,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [15:0]      mem_wdata,
  output logic [1:0]       mem_wbe,
  output logic             mem_re,
  output logic [AW-1:0]    mem_raddr,
  input  logic [15:0]      mem_rdata,
  output logic [1:0]       irq_status,
  input  logic [1:0]       irq_clear,
  output logic [CNT_W-1:0] rx_good_count
);
  localparam int IDX_W      = (RING > 1) ? $clog2(RING) : 1;
  localparam int DESC_SHIFT = $clog2(DESC_BYTES);

  rx_state_e        state;
  logic [IDX_W-1:0] idx;
  logic [31:0]      buf_ptr;
  logic [LEN_W-1:0] cnt;
  logic             mid_frame;
  rx_err_t          err_q;
  rx_class_t        cls_q;
  logic             nodesc_p, done_p, good_p;

  logic [AW-1:0]    ring_base;
  logic [BSZ_W-1:0] buf_size;
  logic             rebase;
  logic [AW-1:0]    desc_addr;
  logic [15:0]      status_word;
  logic             frame_ok;

  logic             start, accept_start, take_byte, byte_store;
  logic [LEN_W-1:0] byte_off;
  logic [AW-1:0]    byte_addr;

  rxwb_cfg #(.AW(AW), .BSZ_W(BSZ_W), .BUF_RESET(BUF_RESET)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ring_base(ring_base), .buf_size(buf_size), .rebase(rebase)
  );

  rxwb_status #(.LEN_W(LEN_W), .BSZ_W(BSZ_W), .MAX_FRAME(MAX_FRAME), .MIN_FRAME(MIN_FRAME)) u_status (
    .len(cnt), .buf_size(buf_size), .err(err_q), .cls(cls_q),
    .status_word(status_word), .frame_ok(frame_ok)
  );

  rxwb_events #(.CNT_W(CNT_W), .IRQ_N(2)) u_events (
    .clk(clk), .rst(rst), .irq_set({nodesc_p, done_p}), .irq_clear(irq_clear),
    .good_pulse(good_p), .irq_status(irq_status), .good_count(rx_good_count)
  );

  always_comb begin
    desc_addr    = ring_base + (AW'(idx) << DESC_SHIFT);
    start        = rx_valid && !mid_frame;
    accept_start = start && (state == S_READY);
    take_byte    = accept_start || (rx_valid && state == S_RECV);
    byte_off     = (state == S_READY) ? '0 : cnt;
    byte_store   = take_byte && (BSZ_W'(byte_off) < buf_size);
    byte_addr    = buf_ptr[AW-1:0] + AW'(byte_off);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_RD_ST;
      idx       <= '0;
      buf_ptr   <= '0;
      cnt       <= '0;
      mid_frame <= 1'b0;
      err_q     <= '0;
      cls_q     <= '0;
      nodesc_p  <= 1'b0;
      done_p    <= 1'b0;
      good_p    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_wbe   <= '0;
      mem_re    <= 1'b0;
      mem_raddr <= '0;
    end else begin
      mem_we   <= 1'b0;
      mem_re   <= 1'b0;
      nodesc_p <= 1'b0;
      done_p   <= 1'b0;
      good_p   <= 1'b0;
      if (rx_valid) mid_frame <= !rx_last;
      if (start && state != S_READY) nodesc_p <= 1'b1;

      case (state)
        S_RD_ST: begin
          mem_re    <= 1'b1;
          mem_raddr <= desc_addr;
          state     <= S_RD_PL;
        end
        S_RD_PL: begin
          mem_re    <= 1'b1;
          mem_raddr <= desc_addr + AW'(4);
          state     <= S_CHK;
        end
        S_CHK: begin
          if (mem_rdata[ST_OWN]) begin
            mem_re    <= 1'b1;
            mem_raddr <= desc_addr + AW'(6);
            state     <= S_GET_PL;
          end else begin
            state <= S_RD_ST;
          end
        end
        S_GET_PL: begin
          buf_ptr[15:0] <= mem_rdata;
          state         <= S_GET_PH;
        end
        S_GET_PH: begin
          buf_ptr[31:16] <= mem_rdata;
          state          <= S_READY;
        end
        S_WB_LEN: begin
          mem_we    <= 1'b1;
          mem_addr  <= desc_addr + AW'(2);
          mem_wdata <= 16'(cnt);
          mem_wbe   <= 2'b11;
          state     <= S_WB_ST;
        end
        S_WB_ST: begin
          mem_we    <= 1'b1;
          mem_addr  <= desc_addr;
          mem_wdata <= status_word;
          mem_wbe   <= 2'b11;
          done_p    <= 1'b1;
          good_p    <= frame_ok;
          idx       <= (int'(idx) == RING - 1) ? '0 : idx + 1'b1;
          state     <= S_RD_ST;
        end
        default: ;
      endcase

      if (take_byte) begin
        if (accept_start)  cnt <= LEN_W'(1);
        else if (cnt != '1) cnt <= cnt + 1'b1;
        if (byte_store) begin
          mem_we    <= 1'b1;
          mem_addr  <= byte_addr;
          mem_wdata <= {rx_data, rx_data};
          mem_wbe   <= byte_addr[0] ? 2'b10 : 2'b01;
        end
        if (rx_last) begin
          err_q <= '{phy_err: rx_phy_err, dribble: rx_dribble, crc_err: rx_crc_err};
          cls_q <= '{bcast: rx_bcast, mcast: rx_mcast, hash_hit: rx_hash_hit,
                     mid_hit: rx_mid_hit, mid_idx: rx_mid_idx};
          state <= S_WB_LEN;
        end else begin
          state <= S_RECV;
        end
      end

      if (rebase && state != S_RECV && state != S_WB_LEN && state != S_WB_ST) begin
        idx   <= '0;
        state <= S_RD_ST;
      end
    end
  end

  a_r1_owned_fetch: assert property (@(posedge clk) disable iff (rst)
    (state == S_GET_PL) |-> $past(mem_rdata[ST_OWN]));

  a_r1_no_rw_clash: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  a_r5_store_in_buffer: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wbe != 2'b11) |-> ((mem_addr - buf_ptr[AW-1:0]) < AW'(buf_size)));

  a_r4_status_after_len: assert property (@(posedge clk) disable iff (rst)
    (state == S_WB_ST) |-> (mem_we && mem_wbe == 2'b11 && mem_addr == desc_addr + AW'(2)));
endmodule

// File: tb/tb_rxwb_engine.sv
module tb_rxwb_engine;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 16384;
  localparam int RING       = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        rx_valid, rx_last, rx_phy_err, rx_dribble, rx_crc_err;
  logic        rx_bcast, rx_mcast, rx_hash_hit, rx_mid_hit;
  logic [1:0]  rx_mid_idx;
  logic [7:0]  rx_data;
  logic        mem_we, mem_re;
  logic [31:0] mem_addr, mem_raddr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [1:0]  mem_wbe, irq_status, irq_clear;
  logic [15:0] rx_good_count;

  logic        host_we;
  logic [31:0] host_addr;
  logic [15:0] host_data;

  logic [7:0]  mem [0:MEM_BYTES-1];
  logic [7:0]  fr  [0:2047];

  int nchk = 0, nerr = 0;
  int cur = 0, base = 32'h200, bsz = 1536, gcount = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxwb_engine dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last),
    .rx_phy_err(rx_phy_err), .rx_dribble(rx_dribble), .rx_crc_err(rx_crc_err),
    .rx_bcast(rx_bcast), .rx_mcast(rx_mcast), .rx_hash_hit(rx_hash_hit),
    .rx_mid_hit(rx_mid_hit), .rx_mid_idx(rx_mid_idx),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wbe(mem_wbe),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .irq_status(irq_status), .irq_clear(irq_clear), .rx_good_count(rx_good_count)
  );

  function automatic int ma(input logic [31:0] a);
    return int'(a[13:0]);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hA5;
      mem_rdata <= '0;
    end else begin
      if (host_we) begin
        mem[ma(host_addr)]     <= host_data[7:0];
        mem[ma(host_addr + 1)] <= host_data[15:8];
      end
      if (mem_we) begin
        if (mem_wbe[0]) mem[ma({mem_addr[31:1], 1'b0})] <= mem_wdata[7:0];
        if (mem_wbe[1]) mem[ma({mem_addr[31:1], 1'b1})] <= mem_wdata[15:8];
      end
      if (mem_re)
        mem_rdata <= {mem[ma({mem_raddr[31:1], 1'b1})], mem[ma({mem_raddr[31:1], 1'b0})]};
    end
  end

  function automatic logic [15:0] rd16(input int a);
    return {mem[ma(a + 1)], mem[ma(a)]};
  endfunction

  function automatic logic [15:0] exp_status(input int len, input int bs, input bit phy,
                                             input bit drib, input bit crc, input logic [5:0] cls);
    logic [15:0] s;
    bit ovf, lng, runt;
    s = '0;
    ovf = len > bs; lng = len > 1518; runt = len < 64;
    s[11] = phy; s[10] = drib; s[9] = ovf; s[8] = lng; s[7] = runt; s[6] = crc;
    if (!(phy || drib || ovf || lng || runt || crc)) begin
      s[14] = 1'b1;
      s[5:0] = cls;
    end
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int a, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_data = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input int len, input bit phy, input bit drib, input bit crc,
                            input logic [5:0] cls);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_data  = fr[i];
      rx_last  = (i == len - 1);
      rx_phy_err = phy; rx_dribble = drib; rx_crc_err = crc;
      {rx_bcast, rx_mcast, rx_hash_hit, rx_mid_hit, rx_mid_idx} = cls;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    idle(30);
  endtask

  task automatic setup_ring(input int b);
    for (int i = 0; i < RING; i++) begin
      host_wr(b + 32 * i + 4, 16'(32'h1000 + 32'h800 * i));
      host_wr(b + 32 * i + 6, 16'h0000);
      host_wr(b + 32 * i, 16'h8000);
    end
  endtask

  task automatic run_frame(input int len, input bit phy, input bit drib, input bit crc,
                           input logic [5:0] cls, input string req);
    int d, bp, stored, bad;
    logic [7:0] sent;
    logic [15:0] es;
    d  = base + 32 * cur;
    bp = int'({rd16(d + 6), rd16(d + 4)});
    for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
    sent = mem[ma(bp + bsz)];
    send_frame(len, phy, drib, crc, cls);
    es = exp_status(len, bsz, phy, drib, crc, cls);
    if (es[14]) gcount++;
    stored = (len < bsz) ? len : bsz;
    bad = 0;
    for (int i = 0; i < stored; i++) if (mem[ma(bp + i)] !== fr[i]) bad++;
    chk({req, " R3 length field"}, 32'(rd16(d + 2)), 32'(len & 12'hFFF));
    chk({req, " R4/R6 status word"}, 32'(rd16(d)), 32'(es));
    chk({req, " R2 buffer bytes mismatches"}, 32'(bad), 32'd0);
    if (len > bsz) chk({req, " R5 byte past buffer untouched"}, 32'(mem[ma(bp + bsz)]), 32'(sent));
    chk({req, " R10 good count"}, 32'(rx_good_count), 32'(gcount));
    host_wr(d, 16'h8000);
    cur = (cur + 1) % RING;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int n_d, snap_len, bp_n;
    logic [7:0] snap_b;
    void'($urandom(32'd2024));
    rst = 1'b1; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    rx_valid = 0; rx_last = 0; rx_data = 0; rx_phy_err = 0; rx_dribble = 0; rx_crc_err = 0;
    rx_bcast = 0; rx_mcast = 0; rx_hash_hit = 0; rx_mid_hit = 0; rx_mid_idx = 0;
    irq_clear = 0; host_we = 0; host_addr = 0; host_data = 0;
    idle(4);
    rst = 1'b0;
    idle(2);
    chk("R9 irq after reset", 32'(irq_status), 32'd0);
    chk("R10 count after reset", 32'(rx_good_count), 32'd0);
    chk("R1 no write after reset", 32'(mem_we), 32'd0);

    setup_ring(base);
    cfg_wr(8'h34, 16'(base));
    cfg_wr(8'h38, 16'h0000);
    idle(20);

    // R8 default buffer size 1536: a 1520-byte frame is long (R5) but fits
    run_frame(1520, 0, 0, 0, 6'h2A, "R8 R5 long frame");
    run_frame(40, 0, 0, 0, 6'h15, "R5 runt");
    run_frame(64, 0, 0, 0, 6'h3F, "R5 min good");

    // random frames across several ring wraps (R7)
    for (int k = 0; k < 20; k++) begin
      int len;
      bit p, dr, c;
      len = 20 + int'($urandom % 280);
      p  = ($urandom % 4) == 0;
      dr = ($urandom % 4) == 0;
      c  = ($urandom % 4) == 0;
      run_frame(len, p, dr, c, 6'($urandom), "R7 random");
    end

    chk("R9 done flag set", 32'(irq_status[0]), 32'd1);
    @(negedge clk); irq_clear = 2'b11;
    @(negedge clk); irq_clear = 2'b00;
    idle(2);
    chk("R9 flags cleared", 32'(irq_status), 32'd0);

    // buffer overflow with a small programmed size
    cfg_wr(8'h18, 16'd100);
    bsz = 100;
    idle(5);
    run_frame(150, 0, 0, 0, 6'h01, "R5 R8 overflow");
    cfg_wr(8'h18, 16'd1536);
    bsz = 1536;
    idle(5);

    // no-descriptor case
    n_d = base + 32 * ((cur + 1) % RING);
    host_wr(n_d, 16'h0000);
    run_frame(80, 0, 0, 0, 6'h00, "R1 before drop");
    snap_len = int'(rd16(n_d + 2));
    bp_n = int'(rd16(n_d + 4));
    snap_b = mem[ma(bp_n)];
    for (int i = 0; i < 80; i++) fr[i] = 8'($urandom);
    send_frame(80, 0, 0, 0, 6'h00);
    chk("R1 no-descriptor flag", 32'(irq_status[1]), 32'd1);
    chk("R1 host-owned status kept", 32'(rd16(n_d)), 32'd0);
    chk("R1 length field untouched", 32'(rd16(n_d + 2)), 32'(snap_len));
    chk("R1 buffer untouched", 32'(mem[ma(bp_n)]), 32'(snap_b));
    chk("R1 R10 count unchanged", 32'(rx_good_count), 32'(gcount));
    host_wr(n_d, 16'h8000);
    idle(20);
    run_frame(90, 0, 0, 0, 6'h12, "R1 R7 after rearm");

    // rebase to a new ring
    setup_ring(32'h600);
    cfg_wr(8'h34, 16'h0600);
    cfg_wr(8'h38, 16'h0000);
    base = 32'h600; cur = 0;
    idle(20);
    run_frame(70, 0, 0, 0, 6'h09, "R8 rebase slot0");
    run_frame(70, 0, 1, 0, 6'h09, "R8 R4 rebase slot1");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule